// File: doc/BRIEF.md
# Sequential Restoring Divider

This block divides one integer by another over several clock cycles and returns a quotient and a remainder. A single-cycle start request captures the two operands and a mode bit that selects unsigned or two's-complement arithmetic. In signed mode the operands are first reduced to their magnitudes. Those magnitudes are divided as unsigned numbers, and the signs are restored on the results.

The divisor is held in a register twice the operand width. It is loaded shifted up by the operand width and moves right by one bit on each step. On each step the running remainder is compared against it. When the remainder is not smaller, the divisor value is subtracted from it and a 1 enters the quotient. Otherwise a 0 enters the quotient and the remainder is left unchanged. After WIDTH+1 such steps and one step that fixes the signs, the results are presented with a one-cycle completion pulse. A zero divisor skips the iteration and reports a flag.

Top module: `seq_divider`

## Requirements
- R1: While reset is held and after it is released, busy, done, div_by_zero, quotient and remainder are all 0 until the first division completes.
- R2: A start pulse is accepted only when busy is low, and busy is high in the cycle after the accepting clock edge. A start pulse seen while busy is high is ignored: it does not change the result of the division already running.
- R3: With is_signed low, the quotient is floor(dividend / divisor) and the remainder is dividend minus quotient times divisor. Both are unsigned WIDTH-bit values, and the remainder is smaller than the divisor.
- R4: For a non-zero divisor, done is high in exactly the one cycle that follows the (WIDTH+2)th rising edge after the accepting edge. busy is low whenever done is high.
- R5: With is_signed high, the operands are two's complement. The quotient is the exact quotient truncated toward zero, and it is negative when the operand signs differ.
- R6: With is_signed high, the remainder is dividend minus quotient times divisor. It is zero or has the sign of the dividend, and its magnitude is smaller than that of the divisor.
- R7: A zero divisor gives div_by_zero = 1, a quotient of all ones and a remainder equal to the dividend bit pattern, in either mode. done rises in the cycle after the first rising edge that follows the accepting edge.
- R8: quotient, remainder and div_by_zero change only in a cycle where done is high, and they hold their values until the next completion.
- R9: In signed mode, the most negative dividend divided by -1 gives the quotient bit pattern with only bit WIDTH-1 set, and a zero remainder.
- R10: A division with a non-zero divisor clears div_by_zero, even when the previous division had a zero divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin a division, sampled on the clock edge |
| is_signed | input | 1 | 1: two's-complement operands, 0: unsigned |
| dividend | input | WIDTH | Number to be divided |
| divisor | input | WIDTH | Number to divide by |
| busy | output | 1 | A division is in progress |
| done | output | 1 | One-cycle pulse when new results are valid |
| quotient | output | WIDTH | Quotient of the last completed division |
| remainder | output | WIDTH | Remainder of the last completed division |
| div_by_zero | output | 1 | The last completed division had a zero divisor |

## Verification
The bench targets four kinds of corner case:
- Operands that sit at the edges of the range: all-ones divided by one, a dividend smaller than the divisor, and the most negative value divided by -1. A design that lost the first iteration step or dropped the top quotient bit would return half or twice the expected quotient in these cases.
- All four sign combinations in signed mode. A sign fix that used the divisor's sign for the remainder, or that rounded toward minus infinity, would give the wrong sign or be off by one.
- A zero divisor followed by a normal division. This exposes a flag that sticks, a wrong quotient or remainder pattern, and a zero-divisor path that waits out the full iteration.
- A second start pulse sent in the middle of a running division. If that pulse reloaded the operands, the first result would be corrupted and its latency would stretch.

// File: rtl/div_pkg.sv
package div_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } div_state_e;

endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep #(
  parameter int WIDTH = 32
) (
  input  logic             is_signed,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic [WIDTH-1:0] mag_a,
  output logic [WIDTH-1:0] mag_b,
  output logic             neg_quo,
  output logic             neg_rem,
  output logic             zero_div
);

  logic sgn_a;
  logic sgn_b;

  always_comb begin
    sgn_a    = is_signed & dividend[WIDTH-1];
    sgn_b    = is_signed & divisor[WIDTH-1];
    mag_a    = sgn_a ? (~dividend + 1'b1) : dividend;
    mag_b    = sgn_b ? (~divisor + 1'b1) : divisor;
    neg_quo  = sgn_a ^ sgn_b;
    neg_rem  = sgn_a;
    zero_div = (divisor == '0);
  end

endmodule

// File: rtl/div_restore_core.sv
module div_restore_core #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [WIDTH-1:0] mag_a,
  input  logic [WIDTH-1:0] mag_b,
  output logic [WIDTH-1:0] quo,
  output logic [WIDTH-1:0] rem
);

  localparam int DW = 2 * WIDTH;

  logic [WIDTH-1:0] rem_q, rem_d;
  logic [DW-1:0]    dvs_q, dvs_d;
  logic [WIDTH-1:0] quo_q, quo_d;
  logic             fits;

  assign fits = ({{WIDTH{1'b0}}, rem_q} >= dvs_q);

  always_comb begin
    rem_d = rem_q;
    dvs_d = dvs_q;
    quo_d = quo_q;
    if (load) begin
      rem_d = mag_a;
      dvs_d = {mag_b, {WIDTH{1'b0}}};
      quo_d = '0;
    end else if (step) begin
      if (fits) begin
        rem_d = rem_q - dvs_q[WIDTH-1:0];
      end
      quo_d = {quo_q[WIDTH-2:0], fits};
      dvs_d = dvs_q >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      dvs_q <= '0;
      quo_q <= '0;
    end else if (load || step) begin
      rem_q <= rem_d;
      dvs_q <= dvs_d;
      quo_q <= quo_d;
    end
  end

  assign quo = quo_q;
  assign rem = rem_q;

endmodule

// File: rtl/div_sign_fix.sv
module div_sign_fix #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] quo_mag,
  input  logic [WIDTH-1:0] rem_mag,
  input  logic             neg_quo,
  input  logic             neg_rem,
  input  logic             zero_div,
  output logic [WIDTH-1:0] quo_out,
  output logic [WIDTH-1:0] rem_out
);

  always_comb begin
    if (zero_div) begin
      quo_out = '1;
    end else if (neg_quo) begin
      quo_out = ~quo_mag + 1'b1;
    end else begin
      quo_out = quo_mag;
    end
    rem_out = neg_rem ? (~rem_mag + 1'b1) : rem_mag;
  end

endmodule

// File: rtl/seq_divider.sv
module seq_divider
  import div_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             is_signed,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder,
  output logic             div_by_zero
);

  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] LAST_STEP = CW'(WIDTH);

  div_state_e       state_q, state_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             negq_q, negr_q, zdiv_q;
  logic             negq_d, negr_d, zdiv_d;
  logic [WIDTH-1:0] res_q_q, res_r_q;
  logic             dz_q, done_q;

  logic             accept, run_en, fix_en;
  logic [WIDTH-1:0] mag_a, mag_b;
  logic             p_negq, p_negr, p_zero;
  logic [WIDTH-1:0] core_quo, core_rem;
  logic [WIDTH-1:0] fix_quo, fix_rem;

  assign accept = start && (state_q == ST_IDLE);
  assign run_en = (state_q == ST_RUN);
  assign fix_en = (state_q == ST_FIX);

  div_operand_prep #(.WIDTH(WIDTH)) u_prep (
    .is_signed (is_signed),
    .dividend  (dividend),
    .divisor   (divisor),
    .mag_a     (mag_a),
    .mag_b     (mag_b),
    .neg_quo   (p_negq),
    .neg_rem   (p_negr),
    .zero_div  (p_zero)
  );

  div_restore_core #(.WIDTH(WIDTH)) u_core (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .step  (run_en),
    .mag_a (mag_a),
    .mag_b (mag_b),
    .quo   (core_quo),
    .rem   (core_rem)
  );

  div_sign_fix #(.WIDTH(WIDTH)) u_fix (
    .quo_mag  (core_quo),
    .rem_mag  (core_rem),
    .neg_quo  (negq_q),
    .neg_rem  (negr_q),
    .zero_div (zdiv_q),
    .quo_out  (fix_quo),
    .rem_out  (fix_rem)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    negq_d  = negq_q;
    negr_d  = negr_q;
    zdiv_d  = zdiv_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          negq_d  = p_negq;
          negr_d  = p_negr;
          zdiv_d  = p_zero;
          cnt_d   = '0;
          state_d = p_zero ? ST_FIX : ST_RUN;
        end
      end
      ST_RUN: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST_STEP) begin
          state_d = ST_FIX;
        end
      end
      ST_FIX: begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      negq_q  <= 1'b0;
      negr_q  <= 1'b0;
      zdiv_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      negq_q  <= negq_d;
      negr_q  <= negr_d;
      zdiv_q  <= zdiv_d;
      done_q  <= fix_en;
    end
  end

  // result registers, enabled only in the fix state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q_q <= '0;
      res_r_q <= '0;
      dz_q    <= 1'b0;
    end else if (fix_en) begin
      res_q_q <= fix_quo;
      res_r_q <= fix_rem;
      dz_q    <= zdiv_q;
    end
  end

  assign busy        = (state_q != ST_IDLE);
  assign done        = done_q;
  assign quotient    = res_q_q;
  assign remainder   = res_r_q;
  assign div_by_zero = dz_q;

endmodule

// File: rtl/div_chk.sv
module div_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] quotient,
  input logic [WIDTH-1:0] remainder,
  input logic             div_by_zero
);

  logic [31:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len <= '0;
    end else if (busy) begin
      run_len <= run_len + 1;
    end else begin
      run_len <= '0;
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R4
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R4
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R2
  AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_by_zero) |-> (run_len == 32'(WIDTH + 2))); // R4
  AST_DBZ_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (done && div_by_zero) |-> (run_len == 32'd1)); // R7
  AST_DBZ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (done && div_by_zero) |-> (quotient == '1)); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(quotient) && $stable(remainder) && $stable(div_by_zero))); // R8

endmodule

bind seq_divider div_chk #(.WIDTH(WIDTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .busy        (busy),
  .done        (done),
  .quotient    (quotient),
  .remainder   (remainder),
  .div_by_zero (div_by_zero)
);

// File: tb/sim_seq_divider.sv
module sim_seq_divider;

  localparam int W = 32;

  logic         clk;
  logic         rst_n;
  logic         start;
  logic         is_signed;
  logic [W-1:0] dividend;
  logic [W-1:0] divisor;
  logic         busy;
  logic         done;
  logic [W-1:0] quotient;
  logic [W-1:0] remainder;
  logic         div_by_zero;

  seq_divider #(.WIDTH(W)) u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .is_signed   (is_signed),
    .dividend    (dividend),
    .divisor     (divisor),
    .busy        (busy),
    .done        (done),
    .quotient    (quotient),
    .remainder   (remainder),
    .div_by_zero (div_by_zero)
  );

  typedef struct {
    logic [W-1:0] q;
    logic [W-1:0] r;
    logic         dz;
    int           acc;
    string        tag;
  } exp_t;

  exp_t sb[$];
  int   n_chk;
  int   n_fail;
  int   cyc;
  bit   finished;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [W-1:0] a, input logic [W-1:0] b,
                                 input logic sg);
    exp_t e;
    logic na, nb;
    logic [W-1:0] ma, mb, uq, ur;
    if (b == '0) begin
      e.q = '1; e.r = a; e.dz = 1'b1;
    end else begin
      na = sg && a[W-1];
      nb = sg && b[W-1];
      ma = na ? (W)'(-a) : a;
      mb = nb ? (W)'(-b) : b;
      uq = ma / mb;
      ur = ma % mb;
      e.q = (na != nb) ? (W)'(-uq) : uq;
      e.r = na ? (W)'(-ur) : ur;
      e.dz = 1'b0;
    end
    return e;
  endfunction

  // driver: waits for idle, pulses start, pushes the expected item
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic sg, input string tag);
    exp_t e;
    @(negedge clk);
    while (busy) @(negedge clk);
    dividend  = a;
    divisor   = b;
    is_signed = sg;
    start     = 1'b1;
    e = model(a, b, sg);
    e.acc = cyc + 1;
    e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic drain;
    while (sb.size() != 0) @(negedge clk);
  endtask

  // monitor: pops and compares on every completion
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        check(1'b0, "R4", "unexpected done", quotient, '0);
      end else begin
        exp_t e;
        int lat;
        e = sb.pop_front();
        lat = e.dz ? 1 : W + 2;
        check(quotient == e.q, e.tag, "quotient", quotient, e.q);
        check(remainder == e.r, e.tag, "remainder", remainder, e.r);
        check(div_by_zero == e.dz, e.tag, "div_by_zero", W'(div_by_zero), W'(e.dz));
        check(cyc - e.acc == lat, e.dz ? "R7" : "R4", "latency",
              W'(cyc - e.acc), W'(lat));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] hq, hr;
    n_chk = 0; n_fail = 0; cyc = 0; finished = 0;
    rst_n = 1'b0; start = 1'b0; is_signed = 1'b0;
    dividend = '0; divisor = '0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !div_by_zero, "R1", "flags in reset",
          W'({busy, done, div_by_zero}), '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(quotient == '0 && remainder == '0 && !busy && !done, "R1",
          "state after reset", quotient | remainder, '0);

    // R3 unsigned cases
    run_op(32'd7, 32'd2, 1'b0, "R3");
    run_op(32'd100, 32'd7, 1'b0, "R3");
    run_op(32'hFFFF_FFFF, 32'd1, 1'b0, "R3");
    run_op(32'd5, 32'd9, 1'b0, "R3");
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R3");
    run_op(32'h8000_0000, 32'd3, 1'b0, "R3");
    // R5/R6 signed sign combinations
    run_op(-32'sd7, 32'sd2, 1'b1, "R5");
    run_op(32'sd7, -32'sd2, 1'b1, "R5");
    run_op(-32'sd7, -32'sd2, 1'b1, "R6");
    run_op(32'sd7, 32'sd2, 1'b1, "R6");
    // R9 most negative over -1
    run_op(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, "R9");
    // R7 zero divisor in both modes, then R10 recovery
    run_op(32'd1234, 32'd0, 1'b0, "R7");
    run_op(-32'sd5, 32'd0, 1'b1, "R7");
    run_op(32'd9, 32'd3, 1'b0, "R10");

    // R2: busy follows acceptance, mid-run start ignored
    drain();
    run_op(32'd1000, 32'd10, 1'b0, "R2");
    check(busy == 1'b1, "R2", "busy after accept", W'(busy), W'(1));
    repeat (3) @(negedge clk);
    dividend = 32'd1; divisor = 32'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    drain();

    // R8: outputs hold after completion
    hq = quotient; hr = remainder;
    repeat (6) @(negedge clk);
    check(quotient == hq, "R8", "quotient hold", quotient, hq);
    check(remainder == hr, "R8", "remainder hold", remainder, hr);

    for (int i = 0; i < 25; i++) begin
      run_op($urandom, $urandom >> ($urandom % 32), 1'b0, "R3");
      run_op($urandom, $urandom >> ($urandom % 32), 1'b1, "R6");
    end
    drain();
    repeat (4) @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule